// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Serial Transmitter

This block turns pairs of linear PCM samples into a single self-clocked serial line. The clock runs at two ticks per bit slot, so every clock cycle produces one half-cell of the line. Each frame carries one left and one right sample, each in its own subframe. A subframe opens with a synchronisation preamble, carries the sample least significant bit first, and ends with four auxiliary slots. A frame counter groups frames into blocks, and the first left-channel preamble of each block is distinct.

Samples arrive through a ready/valid handshake that is offered once per frame. A sample pair accepted at a frame boundary is sent in the frame that follows. If no pair is offered at that boundary, the last pair is sent again and flagged as not valid. The validity, user and channel-status bits for each channel are sampled at every frame boundary. The line is built so that only the preambles contain a 1.5-slot pulse, which a receiver uses to find subframe and block starts.

Top module: `bmc_audio_tx`

## Requirements
- R1: Every slot after the preamble begins with a line transition. A 1 adds a second transition at the middle of the slot, and a 0 has no mid-slot transition.
- R2: Slots 4 to 4+SAMPLE_W-1 carry the sample, LSB first. The first subframe of a frame carries left_i and the second carries right_i.
- R3: The slot after the sample carries validity, the next carries user_i[ch] and the next carries cstat_i[ch], where ch is 0 for the first subframe and 1 for the second.
- R4: Each preamble spans 4 slots (8 half-cells), sent MSB first. The first subframe of block frame 0 uses 11101000, other first subframes use 11100010, and second subframes use 11100100. A pattern is inverted when the line level before it is high.
- R5: The last slot is an even-parity bit, so slots 4 to the end of each subframe carry an even number of ones. Every subframe therefore starts from a low line.
- R6: ready_o is high for exactly one cycle per frame, in the cycle before the frame's last half-cell is driven. A pair present with valid_i in that cycle is sent in the next frame.
- R7: If valid_i is low when ready_o is high, the previous pair is sent again with the validity bit set to 1 in both subframes. Otherwise the validity bit equals vflag_i[ch], which is sampled in the same cycle.
- R8: The frame counter wraps after BLOCK_FRAMES frames, so the block-start preamble appears every BLOCK_FRAMES frames.
- R9: During reset line_o and ready_o are low. The first frame after reset is a block start, carries zero samples with validity 1, and has user and channel-status bits of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cell clock (two ticks per slot) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| left_i | input | SAMPLE_W | Left (first subframe) sample |
| right_i | input | SAMPLE_W | Right (second subframe) sample |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Frame boundary, pair is taken this cycle |
| vflag_i | input | 2 | Per-channel validity flag (1 = not valid) |
| user_i | input | 2 | Per-channel user bit |
| cstat_i | input | 2 | Per-channel channel-status bit |
| line_o | output | 1 | Biphase-mark serial output |

## Verification
The bench builds the block with SAMPLE_W=8 and BLOCK_FRAMES=3. This gives 16-slot subframes and 64-cycle frames, so a run of 24 frames crosses eight block boundaries. The bench decodes every half-cell of every frame. The sample patterns cover all-ones, zero and arithmetic values. The stimulus withholds valid_i in several frames, including two in a row, so repeated pairs and forced validity bits occur alongside block wraps and every preamble type.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int PRE_SLOTS = 4;
  localparam int AUX_SLOTS = 4;

  typedef enum logic [1:0] {PRE_BLK, PRE_LEFT, PRE_RIGHT} pre_kind_e;

  function automatic logic [7:0] pre_pattern(pre_kind_e kind);
    case (kind)
      PRE_BLK:  return 8'b1110_1000;
      PRE_LEFT: return 8'b1110_0010;
      default:  return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmc_slot_seq.sv
module bmc_slot_seq #(
  parameter int SUB_SLOTS    = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int SLOT_W       = 5,
  parameter int FRM_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              half_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sub_o,
  output logic [FRM_W-1:0]  frm_o,
  output logic              last_o
);
  logic              half_q, sub_q;
  logic [SLOT_W-1:0] slot_q;
  logic [FRM_W-1:0]  frm_q;
  logic              slot_end;

  assign slot_end = half_q && (slot_q == SLOT_W'(SUB_SLOTS - 1));
  assign last_o   = slot_end && sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      slot_q <= '0;
      sub_q  <= 1'b0;
      frm_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) slot_q <= slot_end ? '0 : slot_q + 1'b1;
      if (slot_end) sub_q <= ~sub_q;
      if (last_o) frm_q <= (frm_q == FRM_W'(BLOCK_FRAMES - 1)) ? '0 : frm_q + 1'b1;
    end
  end

  assign half_o = half_q;
  assign slot_o = slot_q;
  assign sub_o  = sub_q;
  assign frm_o  = frm_q;
endmodule

// File: rtl/bmc_bit_sel.sv
module bmc_bit_sel #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                half_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                vbit_i,
  input  logic                ubit_i,
  input  logic                cbit_i,
  output logic                bit_o
);
  import bmc_pkg::*;
  localparam int IDX_W    = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam int V_SLOT   = PRE_SLOTS + SAMPLE_W;
  localparam int P_SLOT   = V_SLOT + AUX_SLOTS - 1;

  logic [SLOT_W-1:0] rel;
  logic              par_q;

  assign rel = slot_i - SLOT_W'(PRE_SLOTS);

  always_comb begin
    if (slot_i < SLOT_W'(V_SLOT))           bit_o = sample_i[rel[IDX_W-1:0]];
    else if (slot_i == SLOT_W'(V_SLOT))     bit_o = vbit_i;
    else if (slot_i == SLOT_W'(V_SLOT + 1)) bit_o = ubit_i;
    else if (slot_i == SLOT_W'(V_SLOT + 2)) bit_o = cbit_i;
    else                                    bit_o = par_q;
  end

  // running parity over the data slots, cleared in the preamble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else if (slot_i < SLOT_W'(PRE_SLOTS)) par_q <= 1'b0;
    else if (half_i && slot_i < SLOT_W'(P_SLOT)) par_q <= par_q ^ bit_o;
  end
endmodule

// File: rtl/bmc_line_enc.sv
module bmc_line_enc #(
  parameter int SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        pat_i,
  input  logic              bit_i,
  output logic              line_o
);
  import bmc_pkg::*;
  logic       line_q, pre_lvl_q, lvl, nxt, first;
  logic [2:0] pidx;

  assign first = (slot_i == '0) && !half_i;
  assign pidx  = {slot_i[1:0], half_i};
  assign lvl   = first ? line_q : pre_lvl_q;

  always_comb begin
    if (slot_i < SLOT_W'(PRE_SLOTS)) nxt = pat_i[3'd7 - pidx] ^ lvl;
    else if (!half_i)                nxt = ~line_q;
    else                             nxt = bit_i ? ~line_q : line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= 1'b0;
      pre_lvl_q <= 1'b0;
    end else begin
      line_q <= nxt;
      if (first) pre_lvl_q <= line_q;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx #(
  parameter int SAMPLE_W     = 24,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [1:0]          vflag_i,
  input  logic [1:0]          user_i,
  input  logic [1:0]          cstat_i,
  output logic                line_o
);
  import bmc_pkg::*;
  localparam int SUB_SLOTS = PRE_SLOTS + SAMPLE_W + AUX_SLOTS;
  localparam int SLOT_W    = $clog2(SUB_SLOTS);
  localparam int FRM_W     = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;

  logic              half, sub, last, dbit;
  logic [SLOT_W-1:0] slot;
  logic [FRM_W-1:0]  frm;
  logic [SAMPLE_W-1:0] smp_q [2];
  logic [1:0]        vfl_q, usr_q, cs_q;
  logic              stale_q;
  pre_kind_e         kind;

  bmc_slot_seq #(
    .SUB_SLOTS(SUB_SLOTS), .BLOCK_FRAMES(BLOCK_FRAMES), .SLOT_W(SLOT_W), .FRM_W(FRM_W)
  ) i_seq (
    .clk_i, .rst_ni, .half_o(half), .slot_o(slot), .sub_o(sub), .frm_o(frm), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q[0] <= '0;
      smp_q[1] <= '0;
      vfl_q    <= '0;
      usr_q    <= '0;
      cs_q     <= '0;
      stale_q  <= 1'b1;
    end else if (last) begin
      vfl_q <= vflag_i;
      usr_q <= user_i;
      cs_q  <= cstat_i;
      stale_q <= ~valid_i;
      if (valid_i) begin
        smp_q[0] <= left_i;
        smp_q[1] <= right_i;
      end
    end
  end

  assign ready_o = last;
  assign kind = sub ? PRE_RIGHT : ((frm == '0) ? PRE_BLK : PRE_LEFT);

  bmc_bit_sel #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) i_sel (
    .clk_i, .rst_ni, .half_i(half), .slot_i(slot), .sample_i(smp_q[sub]),
    .vbit_i(vfl_q[sub] | stale_q), .ubit_i(usr_q[sub]), .cbit_i(cs_q[sub]), .bit_o(dbit)
  );

  bmc_line_enc #(.SLOT_W(SLOT_W)) i_enc (
    .clk_i, .rst_ni, .half_i(half), .slot_i(slot), .pat_i(pre_pattern(kind)),
    .bit_i(dbit), .line_o(line_o)
  );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
  parameter int SLOT_W       = 5,
  parameter int FRM_W        = 8,
  parameter int BLOCK_FRAMES = 192
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              half_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic              sub_i,
  input logic [FRM_W-1:0]  frm_i,
  input logic              line_i,
  input logic              ready_i,
  input logic              valid_i,
  input logic              stale_i
);
  assert_slot_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i >= SLOT_W'(4) && !half_i) |=> (line_i != $past(line_i)));

  assert_low_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == '0 && !half_i) |-> !line_i);

  assert_ready_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> (slot_i == '0 && !half_i && !sub_i));

  assert_repeat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !valid_i) |=> stale_i);

  assert_fresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && valid_i) |=> !stale_i);

  assert_block_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && frm_i == FRM_W'(BLOCK_FRAMES - 1)) |=> (frm_i == '0));

  assert_frm_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_i < FRM_W'(BLOCK_FRAMES));
endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(
  .SLOT_W(SLOT_W), .FRM_W(FRM_W), .BLOCK_FRAMES(BLOCK_FRAMES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_i(half), .slot_i(slot), .sub_i(sub),
  .frm_i(frm), .line_i(line_o), .ready_i(ready_o), .valid_i(valid_i), .stale_i(stale_q)
);

// File: tb/test_bmc_audio_tx.sv
module test_bmc_audio_tx;
  localparam int SW     = 8;
  localparam int BLK    = 3;
  localparam int SUB    = SW + 8;
  localparam int HCF    = 4 * SUB;
  localparam int FRAMES = 24;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [SW-1:0] left_i = '0, right_i = '0;
  logic valid_i = 1'b0, ready_o, line_o;
  logic [1:0] vflag_i = '0, user_i = '0, cstat_i = '0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  bmc_audio_tx #(.SAMPLE_W(SW), .BLOCK_FRAMES(BLK)) i_bmc_audio_tx (
    .clk_i, .rst_ni, .left_i, .right_i, .valid_i, .ready_o,
    .vflag_i, .user_i, .cstat_i, .line_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit fbuf [HCF];
  logic [SW-1:0] hold [2], cur_s [2], nxt_s [2];
  logic [1:0] cur_v, cur_u, cur_c, nxt_v, nxt_u, nxt_c;
  bit prev_lvl;

  task automatic check_sub(input int k, input int s);
    int base;
    bit lvl, ok_pre, ok_tr, h0, h1, b;
    logic [7:0] pat;
    logic [SW-1:0] dec;
    int ones;
    bit dv, du, dc;
    base = s * 2 * SUB;
    lvl = (s == 0) ? prev_lvl : fbuf[base-1];
    pat = (s == 1) ? 8'b11100100 : ((k % BLK == 0) ? 8'b11101000 : 8'b11100010);
    ok_pre = 1'b1;
    for (int p = 0; p < 8; p++)
      if (fbuf[base+p] != (pat[7-p] ^ lvl)) ok_pre = 1'b0;
    // R4 preamble kind, R8 block start every BLK frames
    chk(ok_pre, (s == 0 && k % BLK == 0) ? "R8 block preamble" : "R4 preamble",
        ok_pre, 1);
    ok_tr = 1'b1; ones = 0; dec = '0; dv = 0; du = 0; dc = 0;
    for (int i = 4; i < SUB; i++) begin
      h0 = fbuf[base+2*i]; h1 = fbuf[base+2*i+1];
      if (h0 == fbuf[base+2*i-1]) ok_tr = 1'b0;
      b = (h0 != h1);
      ones += b;
      if (i < 4 + SW) dec[i-4] = b;
      else if (i == 4 + SW) dv = b;
      else if (i == 5 + SW) du = b;
      else if (i == 6 + SW) dc = b;
    end
    chk(ok_tr, "R1 slot transitions", ok_tr, 1);
    chk(dec == cur_s[s], "R2 sample", dec, cur_s[s]);
    chk(du == cur_u[s] && dc == cur_c[s], "R3 user/status", {du, dc}, {cur_u[s], cur_c[s]});
    chk(dv == cur_v[s], "R7 validity", dv, cur_v[s]);
    chk(ones % 2 == 0, "R5 parity", ones, ones - ones % 2);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(line_o == 1'b0 && ready_o == 1'b0, "R9 reset outputs", {line_o, ready_o}, 0);
    hold[0] = '0; hold[1] = '0;
    cur_s[0] = '0; cur_s[1] = '0;
    cur_v = 2'b11; cur_u = 2'b00; cur_c = 2'b00;  // R9 first frame contents
    prev_lvl = 1'b0;
    rst_ni = 1'b1;
    for (int k = 0; k < FRAMES; k++) begin
      int nrdy;
      nrdy = 0;
      for (int h = 0; h < HCF; h++) begin
        @(posedge clk_i);
        @(negedge clk_i);
        fbuf[h] = line_o;
        if (h == 0) begin
          valid_i = !(k % 5 == 3 || k == 9);
          left_i  = (k == 1) ? '1 : SW'(k * 29 + 3);
          right_i = (k == 1) ? '0 : SW'((k * 71 + 11) ^ (k << 2));
          vflag_i = (k % 4 == 1) ? 2'b10 : ((k % 6 == 2) ? 2'b01 : 2'b00);
          user_i  = 2'(k);
          cstat_i = 2'(k >> 1);
        end
        if (ready_o) nrdy++;
        if (h == HCF - 2) begin
          chk(ready_o == 1'b1, "R6 ready position", ready_o, 1);
          if (valid_i) begin
            hold[0] = left_i; hold[1] = right_i;
            nxt_v = vflag_i;
          end else nxt_v = 2'b11;  // R7 repeat forces validity bit
          nxt_s[0] = hold[0]; nxt_s[1] = hold[1];
          nxt_u = user_i; nxt_c = cstat_i;
        end
      end
      chk(nrdy == 1, "R6 ready once per frame", nrdy, 1);
      check_sub(k, 0);
      check_sub(k, 1);
      prev_lvl = fbuf[HCF-1];
      cur_s[0] = nxt_s[0]; cur_s[1] = nxt_s[1];
      cur_v = nxt_v; cur_u = nxt_u; cur_c = nxt_c;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule